// File: doc/BRIEF.md
# Permutation Gather Scheduler

This block reorders a vector of N = 2^LOG2N coefficient words before a wavelet kernel sees them. It takes the words in one at a time on a valid/ready stream and stores each one at the next address in the order it arrives. Once the whole vector is stored, the block sends it out K words per beat on a second valid/ready stream. The vector is treated as K equal groups of N/K consecutive words. Beat j carries the j-th word of every group, so each beat holds exactly one member of each group.

The lane count is set by the parameter KLOG2. A value of 1 gives the one-dimensional pairing with two lanes. A value of 2 gives the two-dimensional quad with four lanes. Storage is split into K banks so that all lanes can be read in the same clock. Read addresses are built from an element counter. The column index is the counter shifted right by KLOG2, which is a floor division. The row index is the lane number shifted left into the high address bits. Filling and draining alternate: the block does not overlap two vectors.

Top module: `perm_gather`

## Requirements
- R1: While reset is asserted, and for the first cycles after it is released, `out_valid` is 0. Once the block is out of reset and no word has been taken yet, `in_ready` is 1 and `out_valid` is 0.
- R2: Accepted words are stored at consecutive addresses starting at 0, in the order they are accepted. Cycles in which `in_valid` is low do not advance the address.
- R3: `out_valid` stays 0 until the N-th word of a vector has been accepted. It rises in the cycle after that acceptance.
- R4: While a vector is being drained, `in_ready` is 0. Any word offered on `in_data` in that time is not stored and does not change any output beat.
- R5: On beat j (j = 0 .. N/K-1), lane g carries the word stored at address j + g·(N/K). Lane g occupies bits [g·DW +: DW] of `out_data`.
- R6: With KLOG2 = 1 a vector drains in N/2 beats of 2 lanes. With KLOG2 = 2 it drains in N/4 beats of 4 lanes.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and `out_data` holds its value.
- R8: While `out_ready` stays 1, beats come out on consecutive cycles with no idle cycle until the last beat.
- R9: In the cycle after the last beat is taken, `out_valid` is 0 and `in_ready` is 1. The next vector is then stored starting again at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It is applied asynchronously and released in step with the clock. |
| in_valid | input | 1 | A coefficient word is offered |
| in_ready | output | 1 | The block can take a word (fill phase) |
| in_data | input | DW | Coefficient word |
| out_valid | output | 1 | A permuted beat is available (drain phase) |
| out_ready | input | 1 | The downstream kernel takes the beat |
| out_data | output | K·DW | K lanes. Lane g holds word j + g·N/K. |

## Verification
The checker assumes that nothing changes `in_data` or `out_ready` between clock edges in a way that matters. It also assumes the consumer treats a beat as taken only when valid and ready are both high. The checker keeps its own copy of the words taken during the fill phase and compares each lane against it. This relies on the fill handshake being the only route by which data enters the block.

The bench drives in_valid with gaps while filling. During draining it holds in_valid high with junk data to test R4. It runs three out_ready patterns: always high, alternating, and a sparse pseudo-random one. These are applied to a small 1D instance, a large 2D instance and a mid-size 1D instance.

// File: rtl/perm_gather_pkg.sv
package perm_gather_pkg;

  typedef enum logic {
    PH_FILL  = 1'b0,
    PH_DRAIN = 1'b1
  } phase_e;

endpackage

// File: rtl/perm_rst_sync.sv
module perm_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign srst_n = stage2_q;

endmodule

// File: rtl/perm_bank.sv
module perm_bank #(
  parameter int DW = 16,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      store_q[waddr] <= wdata;
    end
  end

  assign rdata = store_q[raddr];

endmodule

// File: rtl/perm_addr_gen.sv
module perm_addr_gen #(
  parameter int LOG2N = 6,
  parameter int KLOG2 = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        adv,
  output logic                        last,
  output logic [(1<<KLOG2)-1:0][LOG2N-1:0] lane_addr
);

  localparam int K     = 1 << KLOG2;
  localparam int N     = 1 << LOG2N;
  localparam int COL_W = LOG2N - KLOG2;

  logic [LOG2N-1:0] elem_q;
  logic [LOG2N-1:0] elem_d;
  logic [COL_W-1:0] col;

  // element counter advances by K per beat
  always_comb begin
    elem_d = elem_q;
    if (adv) begin
      elem_d = elem_q + LOG2N'(K);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      elem_q <= '0;
    end else if (adv) begin
      elem_q <= elem_d;
    end
  end

  assign last = (elem_q == LOG2N'(N - K));

  // column = floor(elem / K), done as a right shift
  assign col = COL_W'(elem_q >> KLOG2);

  for (genvar g = 0; g < K; g++) begin : g_lane
    localparam logic [LOG2N-1:0] ROW = LOG2N'(g);
    assign lane_addr[g] = (ROW << COL_W) | LOG2N'(col);
  end

endmodule

// File: rtl/perm_gather.sv
module perm_gather
  import perm_gather_pkg::*;
#(
  parameter int LOG2N = 6,
  parameter int KLOG2 = 2,
  parameter int DW    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [DW-1:0]             in_data,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [(1<<KLOG2)*DW-1:0]  out_data
);

  localparam int K     = 1 << KLOG2;
  localparam int N     = 1 << LOG2N;
  localparam int COL_W = LOG2N - KLOG2;

  logic srst_n;

  perm_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  phase_e           phase_q, phase_d;
  logic [LOG2N-1:0] wptr_q, wptr_d;
  logic             wr_fire;
  logic             rd_fire;
  logic             rd_last;
  logic [K-1:0][LOG2N-1:0] lane_addr;
  logic [KLOG2-1:0] wbank;
  logic [COL_W-1:0] wlocal;
  logic [DW-1:0]    bank_rdata [K];

  assign in_ready  = (phase_q == PH_FILL)  && srst_n;
  assign out_valid = (phase_q == PH_DRAIN) && srst_n;
  assign wr_fire   = in_valid && in_ready;
  assign rd_fire   = out_valid && out_ready;

  always_comb begin
    phase_d = phase_q;
    wptr_d  = wptr_q;
    if (wr_fire) begin
      wptr_d = wptr_q + 1'b1;
      if (wptr_q == LOG2N'(N - 1)) begin
        phase_d = PH_DRAIN;
      end
    end
    if (rd_fire && rd_last) begin
      phase_d = PH_FILL;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      phase_q <= PH_FILL;
      wptr_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (wr_fire) begin
        wptr_q <= wptr_d;
      end
    end
  end

  perm_addr_gen #(
    .LOG2N (LOG2N),
    .KLOG2 (KLOG2)
  ) u_addr (
    .clk       (clk),
    .rst_n     (srst_n),
    .adv       (rd_fire),
    .last      (rd_last),
    .lane_addr (lane_addr)
  );

  // write address: high bits pick the group bank, low bits the slot
  assign wbank  = KLOG2'(wptr_q >> COL_W);
  assign wlocal = wptr_q[COL_W-1:0];

  for (genvar b = 0; b < K; b++) begin : g_bank
    perm_bank #(
      .DW (DW),
      .AW (COL_W)
    ) u_bank (
      .clk   (clk),
      .we    (wr_fire && (wbank == KLOG2'(b))),
      .waddr (wlocal),
      .wdata (in_data),
      .raddr (lane_addr[b][COL_W-1:0]),
      .rdata (bank_rdata[b])
    );
  end

  for (genvar g = 0; g < K; g++) begin : g_out
    assign out_data[g*DW +: DW] = bank_rdata[lane_addr[g][LOG2N-1:COL_W]];
  end

endmodule

// File: rtl/perm_gather_chk.sv
module perm_gather_chk #(
  parameter int LOG2N = 6,
  parameter int KLOG2 = 2,
  parameter int DW    = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [DW-1:0]            in_data,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [(1<<KLOG2)*DW-1:0] out_data
);

  localparam int K     = 1 << KLOG2;
  localparam int N     = 1 << LOG2N;
  localparam int BEATS = N / K;
  localparam int COL_W = LOG2N - KLOG2;

  logic [LOG2N-1:0] wcnt_q;
  logic [COL_W-1:0] bcnt_q;
  logic [DW-1:0]    shadow_q [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q <= '0;
      bcnt_q <= '0;
    end else begin
      if (in_valid && in_ready) wcnt_q <= wcnt_q + 1'b1;
      if (out_valid && out_ready) bcnt_q <= bcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid && in_ready) shadow_q[wcnt_q] <= in_data;
  end

  a_r4_phase_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  a_r3_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && wcnt_q != LOG2N'(N - 1)) |=> !out_valid);

  a_r3_drain_start: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && wcnt_q == LOG2N'(N - 1)) |=> (out_valid && !in_ready));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r8_no_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && bcnt_q != COL_W'(BEATS - 1)) |=> out_valid);

  a_r9_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && bcnt_q == COL_W'(BEATS - 1)) |=> (in_ready && !out_valid));

  for (genvar g = 0; g < K; g++) begin : g_lane_chk
    localparam logic [KLOG2-1:0] GS = KLOG2'(g);
    // R5 / R2: lane g carries word bcnt + g*N/K
    a_r5_lane: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_data[g*DW +: DW] == shadow_q[{GS, bcnt_q}]));
  end

endmodule

bind perm_gather perm_gather_chk #(
  .LOG2N (LOG2N),
  .KLOG2 (KLOG2),
  .DW    (DW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/sim_perm_gather.sv
module perm_gather_harness #(
  parameter int LOG2N = 4,
  parameter int KLOG2 = 1,
  parameter int DW    = 16,
  parameter int SEED  = 1
) (
  input  logic clk,
  input  logic rst_n,
  output int   n_checks,
  output int   n_fails,
  output logic done
);

  localparam int K     = 1 << KLOG2;
  localparam int N     = 1 << LOG2N;
  localparam int BEATS = N / K;
  localparam int NVEC  = 3;

  logic              in_valid;
  logic              in_ready;
  logic [DW-1:0]     in_data;
  logic              out_valid;
  logic              out_ready;
  logic [K*DW-1:0]   out_data;

  perm_gather #(
    .LOG2N (LOG2N),
    .KLOG2 (KLOG2),
    .DW    (DW)
  ) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
  );

  // behavioural reference model
  bit              armed = 0;
  bit              m_fill = 1;
  int              m_beat = 0;
  int              m_done = 0;
  bit              m_stalled = 0;
  int              dut_beats = 0;
  int              vec_beats = 0;
  logic [DW-1:0]   m_vec[$];

  always @(posedge clk) begin
    if (armed) begin
      if (out_valid && out_ready) dut_beats++;
      m_stalled = !m_fill && !out_ready;
      if (m_fill) begin
        if (in_valid) begin
          m_vec.push_back(in_data);
          if (m_vec.size() == N) begin
            m_fill = 0;
            m_beat = 0;
          end
        end
      end else if (out_ready) begin
        m_beat++;
        m_stalled = 0;
        if (m_beat == BEATS) begin
          m_fill = 1;
          m_vec.delete();
          vec_beats = dut_beats;
          dut_beats = 0;
          m_done++;
        end
      end
    end
  end

  function automatic logic [DW-1:0] gen_word(int v, int i);
    return DW'(SEED * 7919 + v * 1031 + i * 97 + (i >> 3) * 13);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s (N=%0d K=%0d) actual=%0h expected=%0h", req, N, K, act, exp);
    end
  endtask

  task automatic check_cycle();
    check(out_valid == !m_fill, m_fill ? "R3" : "R8", out_valid, !m_fill);
    check(in_ready == m_fill, m_fill ? "R9" : "R4", in_ready, m_fill);
    if (!m_fill && out_valid) begin
      for (int g = 0; g < K; g++) begin
        logic [DW-1:0] exp_w;
        exp_w = m_vec[m_beat + g * BEATS];
        check(out_data[g*DW +: DW] == exp_w, m_stalled ? "R7" : "R5 R2",
              out_data[g*DW +: DW], exp_w);
      end
    end
  endtask

  initial begin
    n_checks  = 0;
    n_fails   = 0;
    done      = 0;
    in_valid  = 0;
    in_data   = '0;
    out_ready = 0;
    @(negedge clk);
    check(out_valid == 0, "R1", out_valid, 0);
    @(posedge rst_n);
    repeat (4) @(negedge clk);
    check(in_ready == 1, "R1", in_ready, 1);
    check(out_valid == 0, "R1", out_valid, 0);
    armed = 1;
    for (int v = 0; v < NVEC; v++) begin
      int cyc;
      cyc = 0;
      while (m_done <= v) begin
        @(negedge clk);
        check_cycle();
        if (m_fill) begin
          in_valid = ((cyc + v) % 5) != 3;
          in_data  = gen_word(v, m_vec.size());
        end else begin
          in_valid = 1;       // R4: junk offered while draining
          in_data  = DW'(16'hDEAD ^ cyc);
        end
        case (v)
          0:       out_ready = 1;
          1:       out_ready = cyc[0];
          default: out_ready = ((cyc * 37) % 5) != 0;
        endcase
        cyc++;
      end
      @(negedge clk);
      check(vec_beats == BEATS, "R6", vec_beats, BEATS);
      check(in_ready == 1 && out_valid == 0, "R9", {in_ready, out_valid}, 2'b10);
    end
    in_valid = 0;
    repeat (3) @(negedge clk);
    done = 1;
  end

endmodule

module sim_perm_gather;

  logic clk = 0;
  logic rst_n = 0;

  always #10 clk = ~clk;

  int   c0, f0, c1, f1, c2, f2;
  logic d0, d1, d2;
  bit   timed_out = 0;

  perm_gather_harness #(.LOG2N(4),  .KLOG2(1), .SEED(3)) h_small_1d (
    .clk(clk), .rst_n(rst_n), .n_checks(c0), .n_fails(f0), .done(d0));
  perm_gather_harness #(.LOG2N(10), .KLOG2(2), .SEED(5)) h_large_2d (
    .clk(clk), .rst_n(rst_n), .n_checks(c1), .n_fails(f1), .done(d1));
  perm_gather_harness #(.LOG2N(7),  .KLOG2(1), .SEED(9)) h_mid_1d (
    .clk(clk), .rst_n(rst_n), .n_checks(c2), .n_fails(f2), .done(d2));

  initial begin
    int total_c;
    int total_f;
    repeat (5) @(negedge clk);
    rst_n = 1;
    fork
      begin
        wait (d0 === 1'b1 && d1 === 1'b1 && d2 === 1'b1);
      end
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    total_c = c0 + c1 + c2;
    total_f = f0 + f1 + f2;
    if (timed_out) begin
      total_c++;
      total_f++;
      $display("FAIL watchdog R9 actual=timeout expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", total_c, total_f);
    $finish;
  end

endmodule